// File: doc/BRIEF.md
# Two-Channel DMA Request and Transfer Controller

This block gives two DMA channels their request logic, their mode settings and a small sequencer that moves data on a simple bus. Each channel picks one of sixteen request causes through a 4-bit code. The causes are a synchronized falling edge on an external pin, a software trigger, fourteen hardware event strobes, and three alternate event strobes that take the place of three of them when the channel's remap bit is set. A request that arrives latches in a flag. Software can clear that flag but can never set it directly.

Software programs each channel through a byte-wide register port. The port sets the unit size, single or repeat mode, the enable bit, and the stepping direction of the source and destination addresses. It also loads the source and destination addresses and a transfer count, each kept with a reload copy. When an enabled channel has a pending request, the sequencer runs one read cycle at the source address, then one write cycle at the destination address carrying the data it read. It then clears the request and steps the addresses and the count. Channel 0 wins when both channels are pending.

Top module: `dma_ctl`

## Requirements
- R1: After reset every register of both channels reads 0x00 and neither bus_rd nor bus_wr is asserted. Register address = channel*8 + offset, with offset 0 select, 1 control, 2 source address, 3 destination address, 4 count. All other offsets read 0.
- R2: Select register bits [3:0] hold the cause code. Codes 2 to 15 set the request flag (control bit 2) when evt_in[code-2] is high at a clock edge. A strobe on any other input leaves the flag at 0.
- R3: When select bit 4 (remap) is 1, codes 5, 6 and 7 take alt_evt[0], alt_evt[1] and alt_evt[2] in place of evt_in[3], evt_in[4] and evt_in[5], and those evt_in bits are then ignored. When the remap bit is 0, the alt_evt strobes are ignored.
- R4: Writing the select register with bit 7 set and code 0001 sets the request flag. Bit 7 always reads 0. With code 0001 selected, the hardware strobes are ignored.
- R5: Select bits 7:5 and control bits 7:6 read as 0 whatever was written to them.
- R6: Writing control bit 2 (request flag) as 0 clears a pending request. Writing it as 1 leaves the flag unchanged.
- R7: Control bits are: 0 unit (0 = 16-bit, 1 = 8-bit), 1 repeat, 2 request, 3 enable, 4 source forward, 5 destination forward. A control write with bits 4 and 5 both set is rejected as a whole, and the register keeps its previous value.
- R8: Each serviced request gives one read cycle (bus_rd, bus_addr = source) and, on the next cycle, one write cycle (bus_wr, bus_addr = destination, bus_wdata = data read). The flag is then cleared. bus_size8 equals the unit bit.
- R9: After each transfer, a forward address grows by 1 for 8-bit units and by 2 for 16-bit units, and a fixed address does not change.
- R10: Every transfer decrements the count. In single mode, the transfer made with a count of 1 or less leaves the count at 0 and clears the enable bit.
- R11: In repeat mode, the transfer made with a count of 1 or less reloads the count and both addresses from their last written values, and the channel stays enabled.
- R12: A disabled channel latches requests but runs no bus cycle. When both channels are enabled and pending in the same cycle, channel 0 is served first.
- R13: With code 0000 selected, each falling edge of ext_n (after a two-flop synchronizer) sets the request flag exactly once. A pin held low or a rising edge sets nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (channel*8 + offset) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_n | input | 1 | External request pin, falling-edge active |
| evt_in | input | 14 | Hardware event strobes for codes 2 to 15 |
| alt_evt | input | 3 | Alternate strobes for codes 5 to 7 when remapped |
| bus_rd | output | 1 | Bus read cycle |
| bus_wr | output | 1 | Bus write cycle |
| bus_size8 | output | 1 | Current transfer is 8-bit |
| bus_addr | output | 8 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |

## Verification
On every cycle the assertions check the bus cycle order: a read is always followed by a write, and a write is followed by an idle cycle. They also check that no channel ever holds both directions forward, that a read is only ever started for an enabled channel, and that channel 1 is never started while channel 0 was pending. Only the bench scenarios can show the rest. These are the cause mapping with and without remap, the software trigger and write-only bit, the clear-only flag, the address and count stepping, and the single-mode stop and repeat-mode reload. They also include the one-request-per-edge behaviour of the external pin.

// File: rtl/dma_ctl.sv
module dma_ctl #(
  parameter int NCH = 2,
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int RAW = $clog2(NCH) + 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           ext_n,
  input  logic [13:0]    evt_in,
  input  logic [2:0]     alt_evt,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic           bus_size8,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t st;
  logic [CHW-1:0] cur, pick;
  logic [DW-1:0]  data;
  logic [2:0]     xs;
  logic           fall;

  logic [NCH-1:0][3:0]    cause;
  logic [NCH-1:0]         expd, unit8, rpt, req, en, sfwd, dfwd;
  logic [NCH-1:0][AW-1:0] src, dst, src_rl, dst_rl;
  logic [NCH-1:0][CW-1:0] cnt, cnt_rl;
  logic [NCH-1:0]         wsel, hit, swt, clr;
  logic [15:0]            vec;

  wire [RAW-4:0] rch    = reg_addr[RAW-1:3];
  wire [2:0]     off    = reg_addr[2:0];
  wire           ctl_ok = !(reg_wdata[4] && reg_wdata[5]);
  wire           go     = |(en & req);

  assign fall = xs[2] & ~xs[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xs <= 3'b111;
    else        xs <= {xs[1:0], ext_n};

  always_comb begin
    vec = '0;
    for (int i = 0; i < NCH; i++) begin
      wsel[i] = reg_we && (int'(rch) == i);
      vec = {evt_in[13:6], expd[i] ? alt_evt : evt_in[5:3], evt_in[2:0], 1'b0, fall};
      hit[i] = vec[cause[i]];
      swt[i] = wsel[i] && off == 3'd0 && reg_wdata[7] && reg_wdata[3:0] == 4'd1;
      clr[i] = (wsel[i] && off == 3'd1 && ctl_ok && !reg_wdata[2]) ||
               (st == S_WR && cur == CHW'(i));
    end
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en[i] && req[i]) pick = CHW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0; expd <= '0; unit8 <= '0; rpt <= '0; req <= '0; en <= '0;
      sfwd <= '0; dfwd <= '0; src <= '0; dst <= '0; src_rl <= '0; dst_rl <= '0;
      cnt <= '0; cnt_rl <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wsel[i]) begin
          case (off)
            3'd0: begin cause[i] <= reg_wdata[3:0]; expd[i] <= reg_wdata[4]; end
            3'd1: if (ctl_ok) begin
              unit8[i] <= reg_wdata[0]; rpt[i]  <= reg_wdata[1]; en[i] <= reg_wdata[3];
              sfwd[i]  <= reg_wdata[4]; dfwd[i] <= reg_wdata[5];
            end
            3'd2: begin src[i] <= AW'(reg_wdata); src_rl[i] <= AW'(reg_wdata); end
            3'd3: begin dst[i] <= AW'(reg_wdata); dst_rl[i] <= AW'(reg_wdata); end
            3'd4: begin cnt[i] <= CW'(reg_wdata); cnt_rl[i] <= CW'(reg_wdata); end
            default: ;
          endcase
        end
        if (st == S_WR && cur == CHW'(i)) begin
          if (cnt[i] <= CW'(1) && rpt[i]) begin
            src[i] <= src_rl[i]; dst[i] <= dst_rl[i]; cnt[i] <= cnt_rl[i];
          end else begin
            if (sfwd[i]) src[i] <= src[i] + (unit8[i] ? AW'(1) : AW'(2));
            if (dfwd[i]) dst[i] <= dst[i] + (unit8[i] ? AW'(1) : AW'(2));
            if (cnt[i] <= CW'(1)) begin cnt[i] <= '0; en[i] <= 1'b0; end
            else cnt[i] <= cnt[i] - CW'(1);
          end
        end
        req[i] <= hit[i] || swt[i] || (req[i] && !clr[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; data <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin st <= S_RD; cur <= pick; end
        S_RD:   begin data <= bus_rdata; st <= S_WR; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rd    = (st == S_RD);
  assign bus_wr    = (st == S_WR);
  assign bus_addr  = bus_wr ? dst[cur] : src[cur];
  assign bus_wdata = data;
  assign bus_size8 = unit8[cur];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (int'(rch) == i)
        case (off)
          3'd0: reg_rdata = {3'b000, expd[i], cause[i]};
          3'd1: reg_rdata = {2'b00, dfwd[i], sfwd[i], en[i], req[i], rpt[i], unit8[i]};
          3'd2: reg_rdata = 8'(src[i]);
          3'd3: reg_rdata = 8'(dst[i]);
          3'd4: reg_rdata = 8'(cnt[i]);
          default: reg_rdata = '0;
        endcase
  end
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] sfwd,
  input logic [NCH-1:0] dfwd,
  input logic [CHW-1:0] cur
);
  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);

  assert_wr_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (!bus_rd && !bus_wr));

  assert_no_dual_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sfwd & dfwd)));

  assert_rd_only_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> en[cur]);

  assert_ch0_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && cur != '0) |-> !$past(en[0] && req[0]));
endmodule

bind dma_ctl dma_ctl_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .en(en), .req(req), .sfwd(sfwd), .dfwd(dfwd), .cur(cur)
);

// File: tb/dma_ctl_bench.sv
`timescale 1ns/1ps
module dma_ctl_bench;
  logic        clk = 0, rst_n = 0, reg_we = 0, ext_n = 1;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [13:0] evt_in = 0;
  logic [2:0]  alt_evt = 0;
  logic        bus_rd, bus_wr, bus_size8;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  int total = 0, bad = 0, nrd = 0;

  always #4 clk = ~clk;
  assign bus_rdata = {8'hA5, bus_addr};
  always @(posedge clk) if (bus_rd) nrd++;

  dma_ctl u_dma_ctl (.*);

  typedef struct packed {
    logic [3:0] cause; logic expd; logic alt; logic [3:0] idx; logic expq; logic [3:0] rq;
  } vec_t;
  localparam vec_t TBL [9] = '{
    '{4'd2,  1'b0, 1'b0, 4'd0,  1'b1, 4'd2},  // R2 lowest timer code
    '{4'd15, 1'b0, 1'b0, 4'd13, 1'b1, 4'd2},  // R2 vsync-style top code
    '{4'd8,  1'b0, 1'b0, 4'd5,  1'b0, 4'd2},  // R2 wrong strobe
    '{4'd5,  1'b0, 1'b0, 4'd3,  1'b1, 4'd2},  // R2 code 5 normal
    '{4'd5,  1'b1, 1'b0, 4'd3,  1'b0, 4'd3},  // R3 remapped, timer ignored
    '{4'd5,  1'b1, 1'b1, 4'd0,  1'b1, 4'd3},  // R3 alt 0
    '{4'd7,  1'b1, 1'b1, 4'd2,  1'b1, 4'd3},  // R3 alt 2
    '{4'd6,  1'b0, 1'b1, 4'd1,  1'b0, 4'd3},  // R3 alt ignored without remap
    '{4'd1,  1'b0, 1'b0, 4'd0,  1'b0, 4'd4}   // R4 software code ignores hw
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_rd(string tag);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (bus_rd) return;
    end
    check(tag, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset reg", d, 0);
    end
    check("R1 bus idle", {bus_rd, bus_wr}, 0);

    // R2 R3 R4 vector table
    foreach (TBL[n]) begin
      wr(4'd0, {3'b000, TBL[n].expd, TBL[n].cause});
      @(negedge clk);
      if (TBL[n].alt) alt_evt[TBL[n].idx[1:0]] = 1'b1;
      else            evt_in[TBL[n].idx] = 1'b1;
      @(negedge clk); alt_evt = 0; evt_in = 0;
      rd(4'd1, d);
      check($sformatf("R%0d cause vec %0d", TBL[n].rq, n), d[2], TBL[n].expq);
      wr(4'd1, 8'h00);
    end

    // R4 software trigger and write-only bit
    wr(4'd0, 8'h81);
    rd(4'd1, d); check("R4 sw request", d, 8'h04);
    rd(4'd0, d); check("R4 sw bit reads 0", d, 8'h01);
    // R6 write 1 to flag does nothing, write 0 clears
    wr(4'd1, 8'h04);
    rd(4'd1, d); check("R6 write1 keeps flag", d, 8'h04);
    wr(4'd1, 8'h00);
    rd(4'd1, d); check("R6 write0 clears flag", d, 8'h00);
    // R5 unassigned bits
    wr(4'd0, 8'h7F);
    rd(4'd0, d); check("R5 select unused bits", d, 8'h1F);
    wr(4'd1, 8'hC0);
    rd(4'd1, d); check("R5 control unused bits", d, 8'h00);
    // R7 dual forward rejected
    wr(4'd1, 8'h13);
    wr(4'd1, 8'h30);
    rd(4'd1, d); check("R7 dual fwd rejected", d, 8'h13);
    wr(4'd1, 8'h00);

    // R8 R9 16-bit transfer, source forward, destination fixed, single mode
    wr(4'd2, 8'h10); wr(4'd3, 8'h40); wr(4'd4, 8'd3);
    wr(4'd1, 8'h18);
    snap = nrd;
    wr(4'd0, 8'h81);
    wait_rd("R8 read start");
    check("R8 read addr", bus_addr, 8'h10);
    check("R8 size16", bus_size8, 0);
    @(negedge clk);
    check("R8 write cycle", bus_wr, 1);
    check("R8 write addr", bus_addr, 8'h40);
    check("R8 write data", bus_wdata, 16'hA510);
    repeat (5) @(negedge clk);
    check("R8 one transfer", nrd - snap, 1);
    rd(4'd1, d); check("R8 flag cleared", d, 8'h18);
    rd(4'd2, d); check("R9 src +2", d, 8'h12);
    rd(4'd3, d); check("R9 dst fixed", d, 8'h40);
    rd(4'd4, d); check("R10 count dec", d, 8'd2);
    // R10 run to end of count
    wr(4'd0, 8'h81); repeat (6) @(negedge clk);
    wr(4'd0, 8'h81); repeat (6) @(negedge clk);
    rd(4'd1, d); check("R10 enable cleared", d, 8'h10);
    rd(4'd4, d); check("R10 count zero", d, 8'd0);
    rd(4'd2, d); check("R9 src after three", d, 8'h16);

    // R11 repeat mode, 8-bit, destination forward, channel 1
    wr(4'd10, 8'h20); wr(4'd11, 8'h50); wr(4'd12, 8'd2);
    wr(4'd9, 8'h2B);
    wr(4'd8, 8'h81);
    wait_rd("R11 read start");
    check("R11 read addr ch1", bus_addr, 8'h20);
    check("R9 size8", bus_size8, 1);
    repeat (5) @(negedge clk);
    rd(4'd11, d); check("R9 dst +1", d, 8'h51);
    rd(4'd12, d); check("R11 count dec", d, 8'd1);
    wr(4'd8, 8'h81); repeat (6) @(negedge clk);
    rd(4'd11, d); check("R11 dst reload", d, 8'h50);
    rd(4'd12, d); check("R11 count reload", d, 8'd2);
    rd(4'd9, d);  check("R11 stays enabled", d, 8'h2B);

    // R12 disabled channels latch but do not run
    wr(4'd1, 8'h00); wr(4'd9, 8'h00);
    wr(4'd0, 8'h02); wr(4'd8, 8'h02);
    wr(4'd2, 8'h60); wr(4'd4, 8'd5);
    wr(4'd10, 8'h70); wr(4'd12, 8'd5);
    snap = nrd;
    @(negedge clk); evt_in[0] = 1; @(negedge clk); evt_in = 0;
    repeat (5) @(negedge clk);
    check("R12 disabled no bus", nrd - snap, 0);
    rd(4'd1, d); check("R12 disabled latches", d, 8'h04);
    wr(4'd1, 8'h08); wr(4'd9, 8'h08);
    @(negedge clk); evt_in[0] = 1; @(negedge clk); evt_in = 0;
    wait_rd("R12 first read");
    check("R12 ch0 first", bus_addr, 8'h60);
    wait_rd("R12 second read");
    check("R12 ch1 second", bus_addr, 8'h70);
    repeat (4) @(negedge clk);

    // R13 external pin edge
    wr(4'd1, 8'h00); wr(4'd0, 8'h00);
    ext_n = 0;
    repeat (8) @(negedge clk);
    rd(4'd1, d); check("R13 falling edge request", d, 8'h04);
    wr(4'd1, 8'h00);
    repeat (8) @(negedge clk);
    rd(4'd1, d); check("R13 held low once", d, 8'h00);
    ext_n = 1;
    repeat (8) @(negedge clk);
    rd(4'd1, d); check("R13 rising edge ignored", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule